// File: doc/BRIEF.md
# Peripheral Select Interlock Controller

This controller sits between a program-driven processor and a set of peripheral units, of which only one may be connected at any time. The processor issues a select naming a unit and a mode (read, write or control). The controller accepts it at once when no unit is engaged, so the program keeps running. An interlock flag then records that the unit is engaged. Every data word moves through a buffer register, and each word needs its own copy instruction from the program. The controller turns each matched copy into a one-cycle transfer enable in the right direction.

A second select that arrives while a unit is engaged stalls the processor until the earlier operation ends. It ends normally by end-of-record in a data mode, or by the unit's acknowledge in control mode. When the unit offers a word, the program has a programmable number of cycles to issue the copy. If it misses that window, the unit is dropped, the interlock clears, no transfer happens and a sticky status bit records the miss. A copy issued before the unit offers its word stalls the processor until the word strobe arrives.

Top module: `unit_link_ctrl`

## Requirements
- R1: After reset, `engaged`, `proc_stall`, `to_buf_en`, `from_buf_en`, `drop_unit`, `unit_go` and `missed_xfer` are all low.
- R2: A select presented while no unit is engaged is accepted in that cycle without stall. In the next cycle `engaged` is high, `act_unit`/`act_mode` show the request, and `unit_go` is high for exactly that one cycle.
- R3: A select presented while a unit is engaged raises `proc_stall` and leaves `act_unit` and `act_mode` unchanged.
- R4: Mode code 2'b00 is read, 2'b01 is write, and any code with bit 1 set is control. A matched copy in read mode pulses `to_buf_en` for one cycle, and in write mode `from_buf_en`. The two are never high together.
- R5: A copy issued in a data mode before the unit's word strobe holds `proc_stall` high. It completes, with its transfer enable and without stall, in the cycle the strobe arrives.
- R6: A copy is accepted in the strobe cycle or in any of the `win_len` cycles that follow it, including the last one. With `win_len` = 0, only the strobe cycle is accepted.
- R7: If no copy arrives within the window, `drop_unit` pulses in the last window cycle with no transfer enable, and `engaged` is low in the next cycle.
- R8: `missed_xfer` goes high after a missed window and stays high until reset.
- R9: `end_rec` in a data mode clears `engaged` at the next edge. A select held stalled through that cycle is accepted in the following cycle.
- R10: In control mode, copy and word strobe produce no transfer enable and no stall. `unit_ack` clears `engaged` at the next edge.
- R11: A copy issued while no unit is engaged produces neither stall nor transfer enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Select request from processor, held while stalled |
| sel_unit | input | UNIT_W | Unit number of the select |
| sel_mode | input | 2 | Mode of the select (00 read, 01 write, 1x control) |
| copy_req | input | 1 | Copy instruction from processor, held while stalled |
| win_len | input | WIN_W | Copy window length in cycles after the word strobe |
| word_strobe | input | 1 | Unit offers a word (read) or is ready to take one (write) |
| end_rec | input | 1 | Unit signals end of record |
| unit_ack | input | 1 | Unit acknowledges a control command |
| proc_stall | output | 1 | Processor must hold its current select or copy |
| engaged | output | 1 | Interlock flag: a unit is selected |
| act_unit | output | UNIT_W | Unit currently selected |
| act_mode | output | 2 | Mode of the current selection |
| unit_go | output | 1 | One-cycle start pulse to the newly selected unit |
| to_buf_en | output | 1 | Move the offered word from the unit into the buffer register |
| from_buf_en | output | 1 | Move the buffer register word to the unit |
| drop_unit | output | 1 | Disconnect pulse on a missed copy window |
| missed_xfer | output | 1 | Sticky missed-transfer status |

## Verification
The copy path is tried with the copy in the same cycle as the strobe, with the copy arriving exactly in the last window cycle, with the copy arriving before the strobe, and with no copy at all. Together these separate an off-by-one window, a missing stall and a missing disconnect. A window of zero checks the case where only the strobe cycle counts. Selects are tried against an idle link, against an engaged link released by end-of-record, and in control mode released by acknowledge. These show whether the interlock holds the earlier unit and accepts the waiting select only once the link is free.

// File: rtl/unit_link_pkg.sv
package unit_link_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE = 2'b00,
    LNK_DATA = 2'b01,
    LNK_CTRL = 2'b10
  } link_state_e;

  localparam logic [1:0] MODE_RD = 2'b00;
  localparam logic [1:0] MODE_WR = 2'b01;

  // Any mode code with bit 1 set is a control-only select.
  function automatic logic mode_is_ctrl(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/sel_interlock.sv
module sel_interlock
  import unit_link_pkg::*;
#(
  parameter int UNIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_req,
  input  logic [UNIT_W-1:0] sel_unit,
  input  logic [1:0]        sel_mode,
  input  logic              end_rec,
  input  logic              unit_ack,
  input  logic              miss_drop,
  output link_state_e       state,
  output logic [UNIT_W-1:0] act_unit,
  output logic [1:0]        act_mode,
  output logic              unit_go,
  output logic              sel_stall
);

  logic sel_accept;
  logic link_done;

  assign sel_accept = sel_req && (state == LNK_IDLE);
  assign sel_stall  = sel_req && (state != LNK_IDLE);
  assign link_done  = ((state == LNK_DATA) && (end_rec || miss_drop)) ||
                      ((state == LNK_CTRL) && unit_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LNK_IDLE;
      act_unit <= '0;
      act_mode <= MODE_RD;
      unit_go  <= 1'b0;
    end else begin
      unit_go <= sel_accept;
      if (sel_accept) begin
        act_unit <= sel_unit;
        act_mode <= sel_mode;
        state    <= mode_is_ctrl(sel_mode) ? LNK_CTRL : LNK_DATA;
      end else if (link_done) begin
        state <= LNK_IDLE;
      end
    end
  end

  // R3
  held_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stall |=> ($stable(act_unit) && $stable(act_mode)));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> (state == LNK_IDLE));

  // R2
  go_engaged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_go |-> (state != LNK_IDLE));

endmodule

// File: rtl/copy_window.sv
module copy_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_phase,
  input  logic             copy_req,
  input  logic             word_strobe,
  input  logic             end_rec,
  input  logic [WIN_W-1:0] win_len,
  output logic             xfer_fire,
  output logic             copy_stall,
  output logic             miss_drop,
  output logic             missed_sticky
);

  logic             pend;
  logic [WIN_W-1:0] age;
  logic             last_cycle;

  // True when a word has waited through its final permitted cycle.
  function automatic logic window_last(input logic [WIN_W-1:0] a,
                                       input logic [WIN_W-1:0] len);
    return ({1'b0, a} + 1'b1) == {1'b0, len};
  endfunction

  assign last_cycle = window_last(age, win_len);
  assign xfer_fire  = data_phase && copy_req && (pend || word_strobe);
  assign copy_stall = data_phase && copy_req && !pend && !word_strobe;
  assign miss_drop  = data_phase && !end_rec && !copy_req &&
                      ((pend && last_cycle) ||
                       (!pend && word_strobe && (win_len == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend          <= 1'b0;
      age           <= '0;
      missed_sticky <= 1'b0;
    end else begin
      if (miss_drop) missed_sticky <= 1'b1;
      if (!data_phase || end_rec || xfer_fire || miss_drop) begin
        pend <= 1'b0;
        age  <= '0;
      end else if (pend) begin
        age <= age + 1'b1;
      end else if (word_strobe) begin
        pend <= 1'b1;
        age  <= '0;
      end
    end
  end

  // R8
  missed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed_sticky |=> missed_sticky);

  // R7
  miss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_drop |=> (missed_sticky && !pend));

  // R7
  miss_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_drop && xfer_fire));

endmodule

// File: rtl/unit_link_ctrl.sv
module unit_link_ctrl
  import unit_link_pkg::*;
#(
  parameter int UNIT_W = 4,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_req,
  input  logic [UNIT_W-1:0] sel_unit,
  input  logic [1:0]        sel_mode,
  input  logic              copy_req,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              word_strobe,
  input  logic              end_rec,
  input  logic              unit_ack,
  output logic              proc_stall,
  output logic              engaged,
  output logic [UNIT_W-1:0] act_unit,
  output logic [1:0]        act_mode,
  output logic              unit_go,
  output logic              to_buf_en,
  output logic              from_buf_en,
  output logic              drop_unit,
  output logic              missed_xfer
);

  link_state_e state;
  logic        sel_stall;
  logic        copy_stall;
  logic        xfer_fire;
  logic        miss_drop;
  logic        data_phase;

  sel_interlock #(.UNIT_W(UNIT_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_req   (sel_req),
    .sel_unit  (sel_unit),
    .sel_mode  (sel_mode),
    .end_rec   (end_rec),
    .unit_ack  (unit_ack),
    .miss_drop (miss_drop),
    .state     (state),
    .act_unit  (act_unit),
    .act_mode  (act_mode),
    .unit_go   (unit_go),
    .sel_stall (sel_stall)
  );

  assign data_phase = (state == LNK_DATA);

  copy_window #(.WIN_W(WIN_W)) u_win (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_phase    (data_phase),
    .copy_req      (copy_req),
    .word_strobe   (word_strobe),
    .end_rec       (end_rec),
    .win_len       (win_len),
    .xfer_fire     (xfer_fire),
    .copy_stall    (copy_stall),
    .miss_drop     (miss_drop),
    .missed_sticky (missed_xfer)
  );

  assign engaged     = (state != LNK_IDLE);
  assign proc_stall  = sel_stall || copy_stall;
  assign to_buf_en   = xfer_fire && (act_mode == MODE_RD);
  assign from_buf_en = xfer_fire && (act_mode == MODE_WR);
  assign drop_unit   = miss_drop;

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_buf_en, from_buf_en}));

  // R11
  xfer_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_buf_en || from_buf_en) |-> engaged);

  // R7
  drop_unlinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_unit |=> !engaged);

  // R10
  ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && act_mode[1] && unit_ack) |=> !engaged);

endmodule

// File: tb/sim_unit_link_ctrl.sv
`timescale 1ns/1ps
module sim_unit_link_ctrl;

  localparam int UNIT_W = 4;
  localparam int WIN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sel_req;
  logic [UNIT_W-1:0] sel_unit;
  logic [1:0]        sel_mode;
  logic              copy_req;
  logic [WIN_W-1:0]  win_len;
  logic              word_strobe;
  logic              end_rec;
  logic              unit_ack;
  logic              proc_stall;
  logic              engaged;
  logic [UNIT_W-1:0] act_unit;
  logic [1:0]        act_mode;
  logic              unit_go;
  logic              to_buf_en;
  logic              from_buf_en;
  logic              drop_unit;
  logic              missed_xfer;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  unit_link_ctrl #(.UNIT_W(UNIT_W), .WIN_W(WIN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_unit(sel_unit),
    .sel_mode(sel_mode), .copy_req(copy_req), .win_len(win_len),
    .word_strobe(word_strobe), .end_rec(end_rec), .unit_ack(unit_ack),
    .proc_stall(proc_stall), .engaged(engaged), .act_unit(act_unit),
    .act_mode(act_mode), .unit_go(unit_go), .to_buf_en(to_buf_en),
    .from_buf_en(from_buf_en), .drop_unit(drop_unit),
    .missed_xfer(missed_xfer)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Advance to the next negedge; inputs change here, outputs settle by +1ns.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0; sel_req = 1'b0; sel_unit = '0; sel_mode = 2'b00;
    copy_req = 1'b0; word_strobe = 1'b0; end_rec = 1'b0; unit_ack = 1'b0;
    win_len = 8'd3;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  // Issue a select on an idle link and move into the first engaged cycle.
  task automatic select_idle(input logic [UNIT_W-1:0] u, input logic [1:0] m);
    step();
    sel_req = 1'b1; sel_unit = u; sel_mode = m;
    settle();
    check("R2", "stall on idle select", proc_stall, 0);
    step();
    sel_req = 1'b0;
    settle();
    check("R2", "engaged after select", engaged, 1);
    check("R2", "act_unit", act_unit, u);
    check("R2", "act_mode", act_mode, m);
    check("R2", "unit_go pulse", unit_go, 1);
  endtask

  task automatic finish_record();
    step();
    end_rec = 1'b1;
    step();
    end_rec = 1'b0;
    settle();
    check("R9", "engaged after end_rec", engaged, 0);
  endtask

  task automatic t_reset_state();
    settle();
    check("R1", "engaged", engaged, 0);
    check("R1", "proc_stall", proc_stall, 0);
    check("R1", "missed_xfer", missed_xfer, 0);
    check("R1", "to_buf_en", to_buf_en, 0);
    check("R1", "from_buf_en", from_buf_en, 0);
    check("R1", "drop_unit", drop_unit, 0);
    check("R1", "unit_go", unit_go, 0);
  endtask

  task automatic t_idle_copy();
    step();
    copy_req = 1'b1;
    settle();
    check("R11", "stall on idle copy", proc_stall, 0);
    check("R11", "to_buf_en on idle copy", to_buf_en, 0);
    check("R11", "from_buf_en on idle copy", from_buf_en, 0);
    step();
    copy_req = 1'b0;
  endtask

  task automatic t_read_window();
    win_len = 8'd3;
    select_idle(4'd3, 2'b00);
    step();
    settle();
    check("R2", "unit_go single cycle", unit_go, 0);
    // copy together with strobe
    step();
    word_strobe = 1'b1; copy_req = 1'b1;
    settle();
    check("R4", "to_buf_en on read copy", to_buf_en, 1);
    check("R4", "from_buf_en on read copy", from_buf_en, 0);
    check("R6", "stall on same-cycle copy", proc_stall, 0);
    step();
    copy_req = 1'b0;
    settle();
    check("R4", "to_buf_en strobe only", to_buf_en, 0);
    check("R7", "no drop before window end", drop_unit, 0);
    // strobe still high this cycle: word offered; then wait 3 cycles
    step();
    word_strobe = 1'b0;
    step();
    step();
    copy_req = 1'b1;
    settle();
    check("R6", "copy in last window cycle", to_buf_en, 1);
    check("R6", "no drop when copied in last cycle", drop_unit, 0);
    step();
    copy_req = 1'b0;
    settle();
    check("R6", "still engaged after late copy", engaged, 1);
    finish_record();
  endtask

  task automatic t_write_early_copy();
    select_idle(4'd5, 2'b01);
    step();
    copy_req = 1'b1;
    settle();
    check("R5", "stall on early copy", proc_stall, 1);
    check("R5", "no enable before strobe", from_buf_en, 0);
    step();
    settle();
    check("R5", "stall holds", proc_stall, 1);
    step();
    word_strobe = 1'b1;
    settle();
    check("R5", "stall released on strobe", proc_stall, 0);
    check("R4", "from_buf_en on write copy", from_buf_en, 1);
    check("R4", "to_buf_en on write copy", to_buf_en, 0);
    step();
    copy_req = 1'b0; word_strobe = 1'b0;
    finish_record();
  endtask

  task automatic t_second_select();
    select_idle(4'd1, 2'b00);
    step();
    sel_req = 1'b1; sel_unit = 4'd6; sel_mode = 2'b01;
    settle();
    check("R3", "stall on second select", proc_stall, 1);
    step();
    end_rec = 1'b1;
    settle();
    check("R3", "act_unit kept", act_unit, 1);
    check("R3", "act_mode kept", act_mode, 0);
    check("R3", "stall during end_rec cycle", proc_stall, 1);
    step();
    end_rec = 1'b0;
    settle();
    check("R9", "stalled select released", proc_stall, 0);
    check("R9", "interlock cleared", engaged, 0);
    step();
    sel_req = 1'b0;
    settle();
    check("R9", "waiting select engaged", engaged, 1);
    check("R9", "waiting select unit", act_unit, 6);
    check("R9", "waiting select mode", act_mode, 1);
    finish_record();
  endtask

  task automatic t_missed_copy();
    win_len = 8'd2;
    select_idle(4'd2, 2'b00);
    step();
    word_strobe = 1'b1;
    settle();
    check("R7", "no drop at strobe", drop_unit, 0);
    step();
    word_strobe = 1'b0;
    settle();
    check("R7", "no drop in first window cycle", drop_unit, 0);
    step();
    settle();
    check("R7", "drop in last window cycle", drop_unit, 1);
    check("R7", "no enable on miss", to_buf_en, 0);
    step();
    settle();
    check("R7", "disengaged after miss", engaged, 0);
    check("R8", "missed flag set", missed_xfer, 1);
    copy_req = 1'b1;
    settle();
    check("R11", "late copy no stall", proc_stall, 0);
    check("R11", "late copy no enable", to_buf_en, 0);
    step();
    copy_req = 1'b0;
  endtask

  task automatic t_zero_window();
    win_len = 8'd0;
    select_idle(4'd7, 2'b00);
    step();
    word_strobe = 1'b1; copy_req = 1'b1;
    settle();
    check("R6", "zero window same-cycle copy", to_buf_en, 1);
    check("R6", "zero window no drop on copy", drop_unit, 0);
    step();
    copy_req = 1'b0;
    settle();
    check("R7", "zero window drop at strobe", drop_unit, 1);
    step();
    word_strobe = 1'b0;
    settle();
    check("R7", "zero window disengaged", engaged, 0);
    win_len = 8'd3;
  endtask

  task automatic t_control_select();
    select_idle(4'd4, 2'b10);
    step();
    word_strobe = 1'b1; copy_req = 1'b1;
    settle();
    check("R10", "control copy no stall", proc_stall, 0);
    check("R10", "control no to_buf_en", to_buf_en, 0);
    check("R10", "control no from_buf_en", from_buf_en, 0);
    step();
    word_strobe = 1'b0; copy_req = 1'b0;
    settle();
    check("R10", "control still engaged", engaged, 1);
    unit_ack = 1'b1;
    step();
    unit_ack = 1'b0;
    settle();
    check("R10", "control released by ack", engaged, 0);
    check("R8", "missed flag still set", missed_xfer, 1);
  endtask

  task automatic t_reset_clears_flag();
    do_reset();
    settle();
    check("R8", "missed flag cleared by reset", missed_xfer, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_idle_copy();
    t_read_window();
    t_write_early_copy();
    t_second_select();
    t_missed_copy();
    t_zero_window();
    t_control_select();
    t_reset_clears_flag();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule